// File: doc/BRIEF.md
# AXI4-Lite Write-Then-Verify Traffic Master

This block is an AXI4-Lite master that tests a memory on its own once reset is released. It needs no command input. First it writes a fixed number of 32-bit words, one word to each address in a row of consecutive word addresses that starts at a fixed base. After every write has been acknowledged, it reads the same addresses back in the same order. It checks each returned word against a pattern that it computes again from the beat number, so it stores nothing it has written.

Two flags report progress: one for the end of the write phase and one for the end of the read phase. A third output is a sticky error flag. It is set by any data mismatch and by any response other than OKAY on the write-response or read-data channel. The block can be placed in front of any AXI4-Lite slave as a power-on check, or used as a traffic source in system simulation.

Top module: `axil_wrtest_master`

## Requirements
- R1: While reset (`rst_n` low) is asserted, `m_awvalid`, `m_wvalid`, `m_arvalid`, `wr_done`, `rd_done` and `err` are all low.
- R2: After reset, exactly `BEATS` writes are issued. Write i (i = 0 .. BEATS-1) has address `BASE_ADDR + 4*i` and data `32'hA5A5_0000 ^ (i * 32'h0001_0001)`, with `m_wstrb` = 4'hF and both protection fields = 3'b000.
- R3: Once `m_awvalid`, `m_wvalid` or `m_arvalid` is raised, it stays high with its address or data unchanged until the matching ready has been seen.
- R4: At most one write is in flight. A new address or data beat is issued only after the B handshake of the previous write. `wr_done` rises only after the last B handshake, and it then stays high until reset.
- R5: No read address is presented before `wr_done` is high. The reads use the same `BEATS` addresses, in ascending order, with one read in flight at a time.
- R6: `rd_done` rises after the R handshake of the last read, and stays high until reset. From then on, no further address, data or read request is presented.
- R7: A read word that differs from the pattern for its beat sets `err`. `err` stays high until reset, and the test still runs to `rd_done`. When every word matches and every response is OKAY, `err` stays low.
- R8: A `m_bresp` or `m_rresp` that is not OKAY (2'b00) sets the sticky `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_awaddr | output | 32 | Write address |
| m_awprot | output | 3 | Write protection (constant 0) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | 32 | Write data |
| m_wstrb | output | 4 | Write byte strobes (all ones) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | 32 | Read address |
| m_arprot | output | 3 | Read protection (constant 0) |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | 32 | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| wr_done | output | 1 | All writes acknowledged (sticky) |
| rd_done | output | 1 | All reads returned (sticky) |
| err | output | 1 | Mismatch or error response seen (sticky) |

## Verification
The hardest case to reach is a write whose address and data channels are accepted in different cycles, in either order, while the response is held back. Only then does the block show whether it keeps the beat that is already accepted quiet, holds the other one stable, and waits for B before starting the next write. The bench gets there with a slave model whose per-channel ready and response latencies are set separately for each scenario, including one where data is accepted well before the address. Error detection is reached by having the model flip one bit of one returned word, or return a non-OKAY code on a single chosen beat.

// File: rtl/axil_wrtest_master.sv
module axil_wrtest_master #(
  parameter int          BEATS     = 16,
  parameter logic [31:0] BASE_ADDR = 32'h0000_4000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] m_awaddr,
  output logic [2:0]  m_awprot,
  output logic        m_awvalid,
  input  logic        m_awready,
  output logic [31:0] m_wdata,
  output logic [3:0]  m_wstrb,
  output logic        m_wvalid,
  input  logic        m_wready,
  input  logic [1:0]  m_bresp,
  input  logic        m_bvalid,
  output logic        m_bready,
  output logic [31:0] m_araddr,
  output logic [2:0]  m_arprot,
  output logic        m_arvalid,
  input  logic        m_arready,
  input  logic [31:0] m_rdata,
  input  logic [1:0]  m_rresp,
  input  logic        m_rvalid,
  output logic        m_rready,
  output logic        wr_done,
  output logic        rd_done,
  output logic        err
);
  localparam int IW = $clog2(BEATS) + 1;
  localparam logic [IW-1:0] LAST = IW'(BEATS - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_WREQ, ST_WRSP, ST_RREQ, ST_RRSP, ST_DONE} st_t;

  st_t           state;
  logic [IW-1:0] idx;
  logic          aw_pend, w_pend;
  logic          wr_done_q, rd_done_q, err_q;
  logic [31:0]   cur_addr, cur_data;
  logic          aw_ok, w_ok;

  assign cur_addr = BASE_ADDR + (32'(idx) << 2);
  assign cur_data = 32'hA5A5_0000 ^ (32'(idx) * 32'h0001_0001);

  assign m_awaddr  = cur_addr;
  assign m_awprot  = 3'b000;
  assign m_awvalid = (state == ST_WREQ) && aw_pend;
  assign m_wdata   = cur_data;
  assign m_wstrb   = 4'hF;
  assign m_wvalid  = (state == ST_WREQ) && w_pend;
  assign m_bready  = (state == ST_WRSP);
  assign m_araddr  = cur_addr;
  assign m_arprot  = 3'b000;
  assign m_arvalid = (state == ST_RREQ);
  assign m_rready  = (state == ST_RRSP);
  assign wr_done   = wr_done_q;
  assign rd_done   = rd_done_q;
  assign err       = err_q;

  assign aw_ok = !aw_pend || m_awready;
  assign w_ok  = !w_pend  || m_wready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      aw_pend   <= 1'b0;
      w_pend    <= 1'b0;
      wr_done_q <= 1'b0;
      rd_done_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          idx     <= '0;
          aw_pend <= 1'b1;
          w_pend  <= 1'b1;
          state   <= ST_WREQ;
        end
        ST_WREQ: begin
          if (m_awready) aw_pend <= 1'b0;
          if (m_wready)  w_pend  <= 1'b0;
          if (aw_ok && w_ok) state <= ST_WRSP;
        end
        ST_WRSP: if (m_bvalid) begin
          if (m_bresp != 2'b00) err_q <= 1'b1;
          if (idx == LAST) begin
            wr_done_q <= 1'b1;
            idx       <= '0;
            state     <= ST_RREQ;
          end else begin
            idx     <= idx + 1'b1;
            aw_pend <= 1'b1;
            w_pend  <= 1'b1;
            state   <= ST_WREQ;
          end
        end
        ST_RREQ: if (m_arready) state <= ST_RRSP;
        ST_RRSP: if (m_rvalid) begin
          if (m_rresp != 2'b00 || m_rdata != cur_data) err_q <= 1'b1;
          if (idx == LAST) begin
            rd_done_q <= 1'b1;
            state     <= ST_DONE;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_RREQ;
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |=> (!rst_n |-> (!m_awvalid && !m_wvalid && !m_arvalid && !wr_done && !rd_done && !err)));
  a_r3_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr));
  a_r3_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_wvalid && !m_wready |=> m_wvalid && $stable(m_wdata));
  a_r3_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr));
  a_r4_wr_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> wr_done);
  a_r4_no_req_while_resp: assert property (@(posedge clk) disable iff (!rst_n)
    m_bready |-> !m_awvalid && !m_wvalid);
  a_r5_read_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> wr_done);
  a_r6_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> !m_awvalid && !m_wvalid && !m_arvalid && wr_done);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  a_r8_bad_bresp: assert property (@(posedge clk) disable iff (!rst_n)
    m_bvalid && m_bready && m_bresp != 2'b00 |=> err);
endmodule

// File: tb/axil_wrtest_master_tb.sv
module axil_wrtest_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] awaddr, wdata, araddr, rdata;
  logic [2:0]  awprot, arprot;
  logic [3:0]  wstrb;
  logic awvalid, awready, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rvalid, rready;
  logic [1:0] bresp, rresp;
  logic wr_done, rd_done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  axil_wrtest_master #(.BEATS(N), .BASE_ADDR(32'h4000)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .m_awaddr(awaddr), .m_awprot(awprot), .m_awvalid(awvalid), .m_awready(awready),
    .m_wdata(wdata), .m_wstrb(wstrb), .m_wvalid(wvalid), .m_wready(wready),
    .m_bresp(bresp), .m_bvalid(bvalid), .m_bready(bready),
    .m_araddr(araddr), .m_arprot(arprot), .m_arvalid(arvalid), .m_arready(arready),
    .m_rdata(rdata), .m_rresp(rresp), .m_rvalid(rvalid), .m_rready(rready),
    .wr_done(wr_done), .rd_done(rd_done), .err(err));

  int n_chk = 0, n_bad = 0, cyc = 0;
  int aw_lat, w_lat, b_lat, ar_lat, r_lat;
  int corrupt_idx, bad_b_idx, bad_r_idx;

  logic [31:0] mem [64];
  logic [31:0] wa [64], wd [64], ra [64];
  logic [3:0]  ws [64];
  logic [2:0]  wp [64];
  int aw_n, w_n, b_n, ar_n, r_n, ovl;
  int aw_c, w_c, b_c, ar_c, r_c;
  logic aw_got, w_got, ar_got;

  function automatic logic [31:0] pat(int i);
    return 32'hA5A5_0000 ^ (32'(i) * 32'h0001_0001);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      awready <= 0; wready <= 0; bvalid <= 0; arready <= 0; rvalid <= 0;
      bresp <= 0; rresp <= 0; rdata <= 0;
      aw_n <= 0; w_n <= 0; b_n <= 0; ar_n <= 0; r_n <= 0; ovl <= 0;
      aw_c <= 0; w_c <= 0; b_c <= 0; ar_c <= 0; r_c <= 0;
      aw_got <= 0; w_got <= 0; ar_got <= 0;
    end else begin
      awready <= 0;
      if (awvalid && awready) begin
        if (aw_got) ovl <= ovl + 1;
        wa[aw_n & 63] <= awaddr; wp[aw_n & 63] <= awprot;
        aw_n <= aw_n + 1; aw_got <= 1; aw_c <= 0;
      end else if (awvalid) begin
        if (aw_c >= aw_lat) awready <= 1; else aw_c <= aw_c + 1;
      end
      wready <= 0;
      if (wvalid && wready) begin
        if (w_got) ovl <= ovl + 1;
        wd[w_n & 63] <= wdata; ws[w_n & 63] <= wstrb;
        w_n <= w_n + 1; w_got <= 1; w_c <= 0;
      end else if (wvalid) begin
        if (w_c >= w_lat) wready <= 1; else w_c <= w_c + 1;
      end
      if (bvalid && bready) begin
        bvalid <= 0; aw_got <= 0; w_got <= 0; b_c <= 0; b_n <= b_n + 1;
      end else if (aw_got && w_got && !bvalid) begin
        if (b_c >= b_lat) begin
          bvalid <= 1;
          bresp  <= (b_n == bad_b_idx) ? 2'b10 : 2'b00;
          mem[wa[(aw_n-1) & 63][7:2]] <= wd[(w_n-1) & 63];
        end else b_c <= b_c + 1;
      end
      arready <= 0;
      if (arvalid && arready) begin
        if (ar_got) ovl <= ovl + 1;
        ra[ar_n & 63] <= araddr; ar_n <= ar_n + 1; ar_got <= 1; ar_c <= 0;
      end else if (arvalid) begin
        if (ar_c >= ar_lat) arready <= 1; else ar_c <= ar_c + 1;
      end
      if (rvalid && rready) begin
        rvalid <= 0; ar_got <= 0; r_c <= 0; r_n <= r_n + 1;
      end else if (ar_got && !rvalid) begin
        if (r_c >= r_lat) begin
          rvalid <= 1;
          rdata  <= mem[ra[(ar_n-1) & 63][7:2]] ^ ((r_n == corrupt_idx) ? 32'h0000_0100 : 32'h0);
          rresp  <= (r_n == bad_r_idx) ? 2'b10 : 2'b00;
        end else r_c <= r_c + 1;
      end
    end
  end

  logic pv_aw, pr_aw, pv_w, pr_w, pv_ar, pr_ar;
  logic [31:0] pa_aw, pa_w, pa_ar;
  int hold_viol, order_viol;
  always @(negedge clk) begin
    if (!rst_n) begin
      pv_aw <= 0; pv_w <= 0; pv_ar <= 0; pr_aw <= 0; pr_w <= 0; pr_ar <= 0;
    end else begin
      if (pv_aw && !pr_aw && !(awvalid && awaddr == pa_aw)) hold_viol++;
      if (pv_w  && !pr_w  && !(wvalid && wdata == pa_w)) hold_viol++;
      if (pv_ar && !pr_ar && !(arvalid && araddr == pa_ar)) hold_viol++;
      if (arvalid && !wr_done) order_viol++;
      if (wr_done && b_n < N) order_viol++;
      if (bready && (awvalid || wvalid)) order_viol++;
      pv_aw <= awvalid; pr_aw <= awready; pa_aw <= awaddr;
      pv_w  <= wvalid;  pr_w  <= wready;  pa_w  <= wdata;
      pv_ar <= arvalid; pr_ar <= arready; pa_ar <= araddr;
    end
  end

  task automatic start(input int la, lw, lb, lar, lr, cidx, bb, br);
    rst_n = 0;
    aw_lat = la; w_lat = lw; b_lat = lb; ar_lat = lar; r_lat = lr;
    corrupt_idx = cidx; bad_b_idx = bb; bad_r_idx = br;
    hold_viol = 0; order_viol = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!awvalid && !wvalid && !arvalid, "R1 valids low in reset", {29'b0, awvalid, wvalid, arvalid}, 0);
    chk(!wr_done && !rd_done && !err, "R1 flags low in reset", {29'b0, wr_done, rd_done, err}, 0);
    rst_n = 1;
    for (int k = 0; k < 3000 && !rd_done; k++) @(negedge clk);
  endtask

  task automatic t_clean(input int la, lw, lb, lar, lr, input string name);
    int bad_a, bad_d, bad_r;
    start(la, lw, lb, lar, lr, -1, -1, -1);
    bad_a = 0; bad_d = 0; bad_r = 0;
    chk(rd_done === 1'b1, {"R6 rd_done reached ", name}, {31'b0, rd_done}, 1);
    chk(aw_n == N && w_n == N && b_n == N, {"R2 write count ", name}, aw_n, N);
    for (int i = 0; i < N; i++) begin
      if (wa[i] != 32'h4000 + 4*i || wp[i] != 0) bad_a++;
      if (wd[i] != pat(i) || ws[i] != 4'hF) bad_d++;
      if (ra[i] != 32'h4000 + 4*i) bad_r++;
    end
    chk(bad_a == 0, {"R2 write addresses ", name}, bad_a, 0);
    chk(bad_d == 0, {"R2 write data/strobe ", name}, bad_d, 0);
    chk(ar_n == N && r_n == N && bad_r == 0, {"R5 read addresses ", name}, bad_r, 0);
    chk(hold_viol == 0, {"R3 valid held stable ", name}, hold_viol, 0);
    chk(ovl == 0 && order_viol == 0, {"R4 R5 one in flight, ordering ", name}, ovl + order_viol, 0);
    chk(wr_done === 1'b1, {"R4 wr_done high ", name}, {31'b0, wr_done}, 1);
    chk(err === 1'b0, {"R7 no error on clean run ", name}, {31'b0, err}, 0);
    repeat (20) @(negedge clk);
    chk(aw_n == N && ar_n == N && !awvalid && !wvalid && !arvalid && rd_done && wr_done,
        {"R6 idle after done ", name}, ar_n, N);
  endtask

  task automatic t_mismatch();
    start(1, 0, 1, 0, 2, 3, -1, -1);
    chk(rd_done === 1'b1, "R7 mismatch run still finishes", {31'b0, rd_done}, 1);
    chk(err === 1'b1, "R7 err on corrupted word", {31'b0, err}, 1);
    repeat (10) @(negedge clk);
    chk(err === 1'b1, "R7 err sticky", {31'b0, err}, 1);
  endtask

  task automatic t_bad_b();
    start(0, 2, 0, 0, 0, -1, 5, -1);
    chk(err === 1'b1 && rd_done === 1'b1, "R8 err on SLVERR write response", {30'b0, err, rd_done}, 3);
  endtask

  task automatic t_bad_r();
    start(2, 2, 2, 2, 0, -1, -1, N-1);
    chk(err === 1'b1 && rd_done === 1'b1, "R8 err on SLVERR last read response", {30'b0, err, rd_done}, 3);
  endtask

  task automatic t_early_err_kept();
    start(0, 0, 0, 0, 0, 0, -1, -1);
    chk(err === 1'b1, "R7 err from first beat kept to end", {31'b0, err}, 1);
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(err === 1'b0, "R1 err cleared by reset", {31'b0, err}, 0);
  endtask

  initial begin
    fork
      begin
        t_clean(0, 0, 0, 0, 0, "fast");
        t_clean(3, 1, 2, 4, 1, "slow addr");
        t_clean(1, 6, 0, 0, 3, "slow data");
        t_clean(7, 0, 5, 1, 6, "data first");
        t_mismatch();
        t_bad_b();
        t_bad_r();
        t_early_err_kept();
      end
      begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule